// File: doc/BRIEF.md
# Round-Robin Core Clock-Enable Rotator

This block turns a requested number of running cores into a registered per-core clock-enable mask for a multicore cluster. A thermal manager supplies the count once per management interval, and the block marks a contiguous run of cores as enabled. The run wraps around modulo the core count and starts at a rotating pointer. The pointer moves on by one core every interval in which some core is held off. Over many intervals, every core takes its turn being stopped. A stopped core keeps its state, because its clock is held and no reset is applied, so the mask only drives clock-gate enables.

The mask changes only on the interval tick and holds between ticks. A count of zero stops every core. This is the harshest thermal response. A count equal to or above the core total enables all of them, and the pointer is then frozen.

Top module: `rr_core_gate`

## Requirements
- R1: After reset is released, every bit of `core_en_o` is 1 and the rotation pointer is 0, so the first partial mask starts at core 0.
- R2: `core_en_o` changes only in the clock cycle that follows a cycle with `tick_i` high. While `tick_i` is low, changes on `active_cnt_i` have no effect on `core_en_o`.
- R3: After a tick with `active_cnt_i` = k, where k is at most NUM_CORES, exactly k bits of `core_en_o` are 1.
- R4: The enabled bits are cores p, p+1, and so on up to p+k-1, all taken modulo NUM_CORES. Here p is the pointer value when the tick arrived, and bit i of `core_en_o` is core i.
- R5: A tick with `active_cnt_i` below NUM_CORES advances the pointer by one, wrapping from NUM_CORES-1 to 0. Any other tick leaves the pointer unchanged.
- R6: A tick with `active_cnt_i` equal to NUM_CORES sets every enable bit, whatever the pointer value.
- R7: A tick with `active_cnt_i` = 0 clears every enable bit and still advances the pointer.
- R8: A count above NUM_CORES is treated as NUM_CORES: all bits are set and the pointer holds.
- R9: The mask for a tick sampled at a clock edge appears at `core_en_o` right after that same edge, with one register of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Management interval boundary, one cycle per interval |
| active_cnt_i | input | $clog2(NUM_CORES+1) | Number of cores to keep running |
| core_en_o | output | NUM_CORES | Per-core clock enable, bit i for core i |

## Verification
The assertions look at `active_cnt_i` only in cycles where `tick_i` is high. They treat any count at or above the core total as "all on". The random stimulus therefore drives the full width of the count field, including values above the core total. It changes the count freely in cycles without a tick, to show that those values are ignored. Tick density is also random, with bursts of back-to-back ticks and long gaps between them. Directed cases add the count extremes at several pointer positions, including the wrap of the pointer.

// File: rtl/rr_gate_pkg.sv
package rr_gate_pkg;
  parameter int unsigned DefCores = 4;

  function automatic int unsigned cnt_width(input int unsigned cores);
    return $clog2(cores + 1);
  endfunction
endpackage

// File: rtl/rr_gate_ptr.sv
module rr_gate_ptr #(
  parameter int unsigned NUM_CORES = rr_gate_pkg::DefCores,
  localparam int unsigned PTR_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_CORES - 1);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/rr_gate_window.sv
module rr_gate_window #(
  parameter int unsigned NUM_CORES = rr_gate_pkg::DefCores,
  localparam int unsigned CNT_W = rr_gate_pkg::cnt_width(NUM_CORES),
  localparam int unsigned PTR_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [PTR_W-1:0]     ptr_i,
  input  logic [CNT_W-1:0]     cnt_i,   // already clamped to NUM_CORES
  output logic [NUM_CORES-1:0] en_o
);
  logic [CNT_W-1:0] ptr_ext;
  assign ptr_ext = CNT_W'(ptr_i);

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic [CNT_W-1:0] off;
    // distance of core i from the window start, modulo NUM_CORES
    assign off = (CNT_W'(i) >= ptr_ext) ? CNT_W'(i) - ptr_ext
                                        : CNT_W'(i) + CNT_W'(NUM_CORES) - ptr_ext;
    assign en_o[i] = off < cnt_i;
  end
endmodule

// File: rtl/rr_core_gate.sv
module rr_core_gate #(
  parameter int unsigned NUM_CORES = rr_gate_pkg::DefCores,
  localparam int unsigned CNT_W = rr_gate_pkg::cnt_width(NUM_CORES),
  localparam int unsigned PTR_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic [CNT_W-1:0]     active_cnt_i,
  output logic [NUM_CORES-1:0] core_en_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_CORES);

  logic                 some_gated;
  logic [CNT_W-1:0]     cnt_eff;
  logic [PTR_W-1:0]     ptr_q;
  logic [NUM_CORES-1:0] win_mask;
  logic [NUM_CORES-1:0] en_q;

  assign some_gated = active_cnt_i < FULL;
  assign cnt_eff    = some_gated ? active_cnt_i : FULL;

  rr_gate_ptr #(.NUM_CORES(NUM_CORES)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (tick_i && some_gated),
    .ptr_o (ptr_q)
  );

  rr_gate_window #(.NUM_CORES(NUM_CORES)) u_win (
    .ptr_i(ptr_q),
    .cnt_i(cnt_eff),
    .en_o (win_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= '1;
    else if (tick_i) en_q <= win_mask;
  end

  assign core_en_o = en_q;
endmodule

// File: rtl/rr_core_gate_chk.sv
module rr_core_gate_chk #(
  parameter int unsigned NUM_CORES = rr_gate_pkg::DefCores,
  localparam int unsigned CNT_W = rr_gate_pkg::cnt_width(NUM_CORES),
  localparam int unsigned PTR_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tick_i,
  input logic [CNT_W-1:0]     active_cnt_i,
  input logic [PTR_W-1:0]     ptr_q,
  input logic [NUM_CORES-1:0] core_en_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_CORES);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_CORES - 1);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(core_en_o));

  p_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && active_cnt_i <= FULL |=> $countones(core_en_o) == $past(active_cnt_i));

  p_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && active_cnt_i != '0 |=> core_en_o[$past(ptr_q)]);

  p_adv_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && active_cnt_i < FULL |=>
      ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));

  p_hold_ptr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && active_cnt_i < FULL) |=> $stable(ptr_q));

  p_full_r6_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && active_cnt_i >= FULL |=> &core_en_o);

  p_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && active_cnt_i == '0 |=> core_en_o == '0);
endmodule

bind rr_core_gate rr_core_gate_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .active_cnt_i(active_cnt_i),
  .ptr_q       (ptr_q),
  .core_en_o   (core_en_o)
);

// File: tb/rr_core_gate_test.sv
module rr_core_gate_test;
  localparam int N = 4;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tick = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic [N-1:0]  en;

  int errors = 0;
  int checks = 0;
  int m_ptr  = 0;
  logic [N-1:0] m_mask = '1;
  bit done = 0;

  always #5 clk = ~clk;

  rr_core_gate #(.NUM_CORES(N)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .active_cnt_i(cnt), .core_en_o(en)
  );

  function automatic logic [N-1:0] exp_mask(input int p, input int k);
    logic [N-1:0] m = '0;
    int kk = (k > N) ? N : k;
    for (int i = 0; i < N; i++) if (((i - p + N) % N) < kk) m[i] = 1'b1;
    return m;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: core_en=%b expected=%b", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample 1 ns after the next posedge
  task automatic step(input bit t, input int k, input string req);
    @(negedge clk);
    tick = t;
    cnt  = CW'(k);
    @(posedge clk);
    #1;
    if (t) begin
      m_mask = exp_mask(m_ptr, k);
      if (k < N) m_ptr = (m_ptr + 1) % N;
    end
    check(req, en, m_mask);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", en, '1);
    @(negedge clk);
    rst_ni = 1'b1;
    step(0, 0, "R2 idle after reset");
    step(1, 1, "R1 R4 first window at core 0");  // expect 0001
    step(1, 4, "R6 all on ptr=1");
    step(1, 4, "R5 ptr held on full");
    step(1, 2, "R4 window from ptr 1");          // 0110
    step(0, 0, "R2 count change ignored");
    step(0, 3, "R2 count change ignored");
    step(1, 3, "R4 wrap window");                // ptr 2 -> 1101
    step(1, 3, "R5 R4 window ptr 3");            // 1011
    step(1, 0, "R7 zero count");
    step(1, 1, "R5 ptr wrapped");                // ptr 1 -> 0010
    step(1, 7, "R8 over-range count");
    step(1, 5, "R8 over-range count");
    step(1, 1, "R8 ptr held on over-range");     // still ptr 2 -> 0100
    step(1, 0, "R9 back-to-back tick");
    step(1, 4, "R9 back-to-back tick");
    for (int n = 0; n < 400; n++) begin
      bit t = ($urandom_range(0, 2) == 0);
      int k = $urandom_range(0, (1 << CW) - 1);
      step(t, k, t ? "R3 R4 random tick" : "R2 random idle");
      if (t) begin
        checks++;
        if ($countones(en) != ((k > N) ? N : k)) begin
          errors++;
          $display("FAIL R3: ones=%0d expected=%0d", $countones(en), (k > N) ? N : k);
        end
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule